// File: doc/BRIEF.md
# Serial Memory Slave Command Controller

This block is the command front end of a small serial memory that sits behind a four-wire SPI bus. It oversamples the bus pins with the chip's own clock and shifts in command bytes. It decodes six opcodes and answers reads on a serial output that has its own enable, so the pad can float the line between transfers. Storage is a byte array inside the block, reached through an address counter that runs on by itself. A write enable latch guards both the array and the two protect bits of the status byte.

The master may idle the clock low (mode 0) or high (mode 3). The block notes which one from the clock level at the moment chip select falls. Input bits are always taken on clock rising edges, and output bits always change on falling edges. Every command runs from a chip select falling edge to the next rising edge. A rising edge in the middle of a byte abandons that byte.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the write enable latch is 0, a status read returns 0x00 and so_oe is 0.
- R2: The mode is taken from the synchronised SCK level when CS_n falls: low selects mode 0, high selects mode 3. In both modes SI is sampled on SCK rising edges, MSB first. In mode 3 the falling edge that leaves the idle-high level is not a data edge.
- R3: so changes only on SCK falling edges. so_oe is 1 only during the data bytes of a status read (every byte after opcode 0x05) and of a memory read (every byte after the two address bytes of 0x03). It is 0 at all other times, and while CS_n is high.
- R4: Opcode 0x06 sets the write enable latch, which reads back as status bit 1. Nothing else sets it.
- R5: Opcode 0x04 clears the write enable latch, and a later status read shows bit 1 as 0.
- R6: Opcode 0x05 returns the status byte {4'b0000, protect[1:0], latch, 1'b0} on every following byte of the frame.
- R7: Opcode 0x01 followed by a data byte copies data bits 3:2 into the protect bits, but only when the latch is 1. Status bits 7:4, 1 and 0 cannot be written this way.
- R8: Opcode 0x02 stores each complete data byte at the current address and then steps the address. With the latch at 0 the array does not change.
- R9: The latch clears on the CS_n rising edge that ends a frame whose opcode was 0x01, 0x02 or 0x04.
- R10: Opcodes 0x03 and 0x02 take a two-byte address, of which only the low 11 bits are used. The address steps by one after each data byte and wraps from 0x7FF to 0x000.
- R11: A CS_n rising edge in the middle of a byte abandons the frame. A partly shifted write byte is not stored, and a partly shifted opcode has no effect.
- R12: An opcode byte outside the six listed makes the rest of the frame have no effect, and so_oe stays 0 for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out, valid while so_oe is 1 |
| so_oe | output | 1 | Output enable for the so pad driver |

## Verification
Each pin passes through two synchroniser flops. An edge is then seen by comparison with a one-cycle-delayed copy, and so and so_oe are registered. A pin change therefore shows at the outputs on the third clock edge after it. The bench holds every SCK half period for six clocks and samples so and so_oe in the last clock before it raises SCK, so each bit is read after it has settled and before the next edge can move it. Latch and protect changes are checked through a status read in a later frame, begun after a six-clock wait with CS_n high. That wait is long enough for the deselect edge to reach the latch.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;

  // status byte layout
  localparam int ST_LATCH_BIT = 1;
  localparam int ST_PROT_LO   = 2;
  localparam int ST_PROT_HI   = 3;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_RD_STAT,
    PH_WR_STAT,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/spim_rst_sync.sv
module spim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/spim_pin_sync.sv
module spim_pin_sync #(
  parameter int            WIDTH   = 3,
  parameter int            STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = pin_i;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spim_byte_array.sv
module spim_byte_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/spim_cmd_ctrl.sv
module spim_cmd_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              sck_s,
  input  logic              cs_s,
  input  logic              si_s,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              wel_o,
  output logic [1:0]        bp_o,
  output logic              cmd_stb_o,
  output logic [7:0]        cmd_code_o,
  output logic              desel_o,
  output logic              sck_fall_o
);

  localparam int HI_W = ADDR_W - 8;

  // registers
  phase_e            phase_q, phase_n;
  logic [2:0]        bit_q, bit_n;
  logic [6:0]        sh_q, sh_n;
  logic              mode3_q, mode3_n;
  logic              armed_q, armed_n;
  logic              rd_cmd_q, rd_cmd_n;
  logic [HI_W-1:0]   ahi_q, ahi_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              wel_q, wel_n;
  logic [1:0]        bp_q, bp_n;
  logic              clr_pend_q, clr_pend_n;
  logic [7:0]        rd_byte_q, rd_byte_n;
  logic              so_q, so_n;
  logic              oe_q, oe_n;
  logic              sck_d_q, cs_d_q;

  // edge detection on synchronised pins
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_fall  = ~cs_s & cs_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;

  logic       take, byte_done;
  logic [7:0] rx_byte, status;
  assign take      = sck_rise & ~cs_s & armed_q;
  assign byte_done = take & (bit_q == 3'd7);
  assign rx_byte   = {sh_q, si_s};

  always_comb begin
    status = '0;
    status[ST_LATCH_BIT]           = wel_q;
    status[ST_PROT_HI:ST_PROT_LO]  = bp_q;
  end

  // next-state logic
  always_comb begin
    phase_n    = phase_q;
    bit_n      = bit_q;
    sh_n       = sh_q;
    mode3_n    = mode3_q;
    armed_n    = armed_q;
    rd_cmd_n   = rd_cmd_q;
    ahi_n      = ahi_q;
    addr_n     = addr_q;
    wel_n      = wel_q;
    bp_n       = bp_q;
    clr_pend_n = clr_pend_q;
    rd_byte_n  = rd_byte_q;
    so_n       = so_q;
    oe_n       = oe_q;
    mem_we     = 1'b0;
    mem_addr   = addr_q;
    mem_wdata  = rx_byte;

    if (cs_fall) begin
      phase_n    = PH_OPC;
      bit_n      = '0;
      mode3_n    = sck_s;
      armed_n    = ~sck_s;
      oe_n       = 1'b0;
      clr_pend_n = 1'b0;
    end else if (cs_rise) begin
      phase_n    = PH_IDLE;
      bit_n      = '0;
      oe_n       = 1'b0;
      clr_pend_n = 1'b0;
      if (clr_pend_q) wel_n = 1'b0;
    end else if (!cs_s) begin
      if (mode3_q && !armed_q && sck_fall) armed_n = 1'b1;

      if (take) begin
        sh_n  = rx_byte[6:0];
        bit_n = bit_q + 3'd1;
      end

      if (byte_done) begin
        case (phase_q)
          PH_OPC: begin
            case (rx_byte)
              OPC_WREN: begin
                wel_n   = 1'b1;
                phase_n = PH_SKIP;
              end
              OPC_WRDI: begin
                wel_n      = 1'b0;
                clr_pend_n = 1'b1;
                phase_n    = PH_SKIP;
              end
              OPC_RDSR: begin
                rd_byte_n = status;
                phase_n   = PH_RD_STAT;
              end
              OPC_WRSR: begin
                clr_pend_n = 1'b1;
                phase_n    = PH_WR_STAT;
              end
              OPC_READ: begin
                rd_cmd_n = 1'b1;
                phase_n  = PH_ADDR_HI;
              end
              OPC_WRITE: begin
                rd_cmd_n   = 1'b0;
                clr_pend_n = 1'b1;
                phase_n    = PH_ADDR_HI;
              end
              default: phase_n = PH_SKIP;
            endcase
          end
          PH_ADDR_HI: begin
            ahi_n   = rx_byte[HI_W-1:0];
            phase_n = PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            mem_addr = {ahi_q, rx_byte};
            if (rd_cmd_q) begin
              rd_byte_n = mem_rdata;
              addr_n    = {ahi_q, rx_byte} + ADDR_W'(1);
              phase_n   = PH_RD_DATA;
            end else begin
              addr_n  = {ahi_q, rx_byte};
              phase_n = PH_WR_DATA;
            end
          end
          PH_RD_DATA: begin
            rd_byte_n = mem_rdata;
            addr_n    = addr_q + ADDR_W'(1);
          end
          PH_WR_DATA: begin
            mem_we = wel_q;
            addr_n = addr_q + ADDR_W'(1);
          end
          PH_RD_STAT: rd_byte_n = status;
          PH_WR_STAT: begin
            if (wel_q) bp_n = rx_byte[ST_PROT_HI:ST_PROT_LO];
            phase_n = PH_SKIP;
          end
          default: ;
        endcase
      end

      if (sck_fall && (phase_q == PH_RD_DATA || phase_q == PH_RD_STAT)) begin
        so_n = rd_byte_q[3'd7 - bit_q];
        oe_n = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q    <= PH_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      mode3_q    <= 1'b0;
      armed_q    <= 1'b0;
      rd_cmd_q   <= 1'b0;
      ahi_q      <= '0;
      addr_q     <= '0;
      wel_q      <= 1'b0;
      bp_q       <= '0;
      clr_pend_q <= 1'b0;
      rd_byte_q  <= '0;
      so_q       <= 1'b0;
      oe_q       <= 1'b0;
      sck_d_q    <= 1'b0;
      cs_d_q     <= 1'b1;
    end else begin
      phase_q    <= phase_n;
      bit_q      <= bit_n;
      sh_q       <= sh_n;
      mode3_q    <= mode3_n;
      armed_q    <= armed_n;
      rd_cmd_q   <= rd_cmd_n;
      ahi_q      <= ahi_n;
      addr_q     <= addr_n;
      wel_q      <= wel_n;
      bp_q       <= bp_n;
      clr_pend_q <= clr_pend_n;
      rd_byte_q  <= rd_byte_n;
      so_q       <= so_n;
      oe_q       <= oe_n;
      sck_d_q    <= sck_s;
      cs_d_q     <= cs_s;
    end
  end

  assign so_o       = so_q;
  assign so_oe_o    = oe_q;
  assign wel_o      = wel_q;
  assign bp_o       = bp_q;
  assign cmd_stb_o  = byte_done & (phase_q == PH_OPC) & ~cs_s;
  assign cmd_code_o = rx_byte;
  assign desel_o    = cs_rise;
  assign sck_fall_o = sck_fall;

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);

  logic              rst_sn;
  logic [2:0]        pins_s;
  logic              sck_s, cs_s, si_s;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              wel, cmd_stb, desel, sck_fall;
  logic [1:0]        bp;
  logic [7:0]        cmd_code;

  spim_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // bit 2: sck, bit 1: cs_n (idles high), bit 0: si
  spim_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pins (
    .clk    (clk),
    .rst_sn (rst_sn),
    .pin_i  ({sck, cs_n, si}),
    .sync_o (pins_s)
  );

  assign sck_s = pins_s[2];
  assign cs_s  = pins_s[1];
  assign si_s  = pins_s[0];

  spim_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .sck_s      (sck_s),
    .cs_s       (cs_s),
    .si_s       (si_s),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .so_o       (so),
    .so_oe_o    (so_oe),
    .wel_o      (wel),
    .bp_o       (bp),
    .cmd_stb_o  (cmd_stb),
    .cmd_code_o (cmd_code),
    .desel_o    (desel),
    .sck_fall_o (sck_fall)
  );

  spim_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spi_mem_pkg::*;
(
  input logic       clk,
  input logic       rst_sn,
  input logic       cs_s,
  input logic       sck_fall,
  input logic       so,
  input logic       so_oe,
  input logic       wel,
  input logic [1:0] bp,
  input logic       mem_we,
  input logic       cmd_stb,
  input logic [7:0] cmd_code,
  input logic       desel
);

  AST_OE_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_sn)
    (cs_s && $past(cs_s)) |-> !so_oe);  // R3

  AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_sn)
    !sck_fall |=> $stable(so));  // R3

  AST_LATCH_SET_BY_WREN: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(wel) |-> $past(cmd_stb && cmd_code == OPC_WREN));  // R4

  AST_LATCH_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(wel) |-> $past(desel || (cmd_stb && cmd_code == OPC_WRDI)));  // R9

  AST_ARRAY_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |-> wel);  // R8

  AST_PROTECT_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(bp) |-> $past(wel));  // R7

  AST_ARRAY_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |-> !cs_s);  // R11

endmodule

bind spi_mem_slave spim_checker u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .cs_s     (cs_s),
  .sck_fall (sck_fall),
  .so       (so),
  .so_oe    (so_oe),
  .wel      (wel),
  .bp       (bp),
  .mem_we   (mem_we),
  .cmd_stb  (cmd_stb),
  .cmd_code (cmd_code),
  .desel    (desel)
);

// File: tb/spi_mem_slave_tb.sv
`timescale 1ns/1ps
module spi_mem_slave_tb;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si;
  logic so, so_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int idle_cnt = 0;

  // behavioural model state
  logic       m_wel;
  logic [1:0] m_bp;
  logic [7:0] m_mem [2048];

  always #2.5 clk = ~clk;

  spi_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // every clock: with CS_n idle for a while, the output must be disabled (R3)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && cs_n === 1'b1) idle_cnt <= idle_cnt + 1;
    else idle_cnt <= 0;
    if (idle_cnt > 4 && !done)
      chk(so_oe === 1'b0, "R3", "so_oe while deselected", int'(so_oe), 0);
  end

  task automatic hw();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] m_status();
    return {4'b0000, m_bp, m_wel, 1'b0};
  endfunction

  // one frame: n full bytes from v (byte 0 leftmost), then 'extra' bits of part
  task automatic txn(input bit m3, input int n, input logic [63:0] v,
                     input int extra, input logic [7:0] part, input string req);
    logic [7:0] tx [8];
    logic [7:0] exp [8];
    bit         eoe [8];
    logic [10:0] a;
    for (int i = 0; i < 8; i++) begin
      tx[i]  = (i < n) ? v[8*(n-1-i) +: 8] : 8'h00;
      exp[i] = 8'h00;
      eoe[i] = 0;
    end
    // reference model
    if (n >= 1) begin
      case (tx[0])
        8'h06: m_wel = 1'b1;
        8'h04: m_wel = 1'b0;
        8'h05: for (int i = 1; i < n; i++) begin eoe[i] = 1; exp[i] = m_status(); end
        8'h01: begin
          if (n >= 2 && m_wel) m_bp = tx[1][3:2];
          m_wel = 1'b0;
        end
        8'h03: if (n >= 3) begin
          a = {tx[1][2:0], tx[2]};
          for (int i = 3; i < n; i++) begin eoe[i] = 1; exp[i] = m_mem[a]; a = a + 11'd1; end
        end
        8'h02: begin
          if (n >= 3 && m_wel) begin
            a = {tx[1][2:0], tx[2]};
            for (int i = 3; i < n; i++) begin m_mem[a] = tx[i]; a = a + 11'd1; end
          end
          m_wel = 1'b0;
        end
        default: ;
      endcase
    end
    // drive the frame
    sck = m3;
    hw();
    cs_n = 1'b0;
    hw();
    for (int i = 0; i <= n; i++) begin
      logic [7:0] rx = 8'h00;
      bit oe_all = 1, oe_any = 0;
      int nb = (i < n) ? 8 : extra;
      for (int b = 0; b < nb; b++) begin
        sck = 1'b0;
        si  = (i < n) ? tx[i][7-b] : part[7-b];
        hw();
        rx[7-b] = so;
        if (so_oe !== 1'b1) oe_all = 0;
        if (so_oe !== 1'b0) oe_any = 1;
        sck = 1'b1;
        hw();
      end
      if (i < n) begin
        if (eoe[i]) begin
          chk(oe_all, req, $sformatf("so_oe on read byte %0d", i), int'(oe_all), 1);
          chk(rx === exp[i], req, $sformatf("read byte %0d", i), int'(rx), int'(exp[i]));
        end else begin
          chk(!oe_any, req, $sformatf("so_oe on non-read byte %0d", i), int'(oe_any), 0);
        end
      end
    end
    if (!m3) begin sck = 1'b0; hw(); end
    cs_n = 1'b1;
    hw();
    hw();
  endtask

  task automatic rdsr(input bit m3, input string req);
    txn(m3, 3, 64'h05_00_00, 0, 8'h00, req);
  endtask

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
    m_wel = 1'b0; m_bp = 2'b00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    hw();

    // R1: reset state
    chk(so_oe === 1'b0, "R1", "so_oe after reset", int'(so_oe), 0);
    rdsr(0, "R1 R6");

    // R4: WREN sets the latch (status bit 1)
    txn(0, 1, 64'h06, 0, 8'h00, "R4");
    rdsr(0, "R4");

    // R5: WRDI clears it
    txn(0, 1, 64'h04, 0, 8'h00, "R5");
    rdsr(0, "R5");

    // R7 R9: WRSR with latch writes bits 3:2 only, latch clears at deselect
    txn(0, 1, 64'h06, 0, 8'h00, "R4");
    txn(0, 2, 64'h01_FF, 0, 8'h00, "R7");
    rdsr(0, "R7 R9");

    // R7: WRSR without latch has no effect
    txn(0, 2, 64'h01_00, 0, 8'h00, "R7");
    rdsr(0, "R7");

    // R10 R8: write across the wrap with upper address bits set
    txn(0, 1, 64'h06, 0, 8'h00, "R4");
    txn(0, 7, 64'hFF_02_FF_FE_A1_B2_C3_D4 & 64'h00FF_FFFF_FFFF_FFFF, 0, 8'h00, "R10");
    rdsr(0, "R9");
    txn(0, 7, 64'h03_07_FE_00_00_00_00, 0, 8'h00, "R10");

    // R8: write without latch leaves the array alone
    txn(0, 4, 64'h02_00_00_5A, 0, 8'h00, "R8");
    txn(0, 5, 64'h03_00_00_00_00, 0, 8'h00, "R8");

    // R2: mode 3 write and read back
    txn(1, 1, 64'h06, 0, 8'h00, "R2");
    txn(1, 5, 64'h02_00_10_33_44, 0, 8'h00, "R2");
    txn(1, 5, 64'h03_00_10_00_00, 0, 8'h00, "R2");
    rdsr(1, "R2 R9");

    // R11: abort inside a data byte
    txn(0, 1, 64'h06, 0, 8'h00, "R4");
    txn(0, 4, 64'h02_00_10_55, 4, 8'hAA, "R11");
    txn(0, 5, 64'h03_00_10_00_00, 0, 8'h00, "R11");
    rdsr(0, "R11 R9");

    // R12: unknown opcode ignored, latch kept
    txn(0, 1, 64'h06, 0, 8'h00, "R4");
    txn(0, 4, 64'h0B_00_00_00, 0, 8'h00, "R12");
    rdsr(0, "R12");

    // R11: partly shifted opcode has no effect
    txn(0, 1, 64'h04, 0, 8'h00, "R5");
    txn(0, 0, 64'h0, 7, 8'h06, "R11");
    rdsr(0, "R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule